// File: doc/BRIEF.md
# Serial Receiver with Multiprocessor Address Filter

This block is an asynchronous serial receiver. It samples the receive line on a sixteen-per-bit oversampling strobe that comes from outside the block. It takes in either a short frame or a long frame. A short frame is a start bit, eight data bits and a stop bit. A long frame is a start bit, eight data bits, an extra ninth bit and a stop bit. When a frame is accepted, the block places the data byte and a ninth-bit value on its outputs and raises a sticky "frame ready" flag. A separate sticky flag reports a bad stop bit.

The block also has a multiprocessor filter. When the filter is on, only frames whose ninth bit is 1 can be accepted. Such a frame is an address frame, and its byte must match either the unit's own address or the broadcast address. Both addresses are built from an address byte and an enable mask. A frame that fails the filter, or that arrives while the ready flag is still set, is discarded without trace. The consumer of the data clears the two flags through dedicated pulse inputs.

Top module: `serial_rx_filter`

## Requirements
- R1: A frame starts with a 0 bit followed by eight data bits, least significant bit first. The received byte appears on `data_o` together with `done_o` = 1.
- R2: With `long_frame_i` = 0, the value sampled in the stop-bit position is presented on `bit9_o`.
- R3: With `long_frame_i` = 1, the bit between the eighth data bit and the stop bit is presented on `bit9_o`.
- R4: Reception starts only on a 1-to-0 change of the line seen on consecutive oversampling strobes. A line held low from reset onward starts nothing.
- R5: While `done_o` is 1, a completed frame is lost: `data_o`, `bit9_o` and `done_o` keep their values.
- R6: With `mp_en_i` = 1, a frame whose ninth bit (the stop bit when `long_frame_i` = 0) is 0 is dropped and `done_o` stays 0.
- R7: With `mp_en_i` = 1, an address frame is accepted when every byte bit whose `addr_mask_i` bit is 1 equals the matching `addr_i` bit. Mask bits of 0 are don't-cares.
- R8: With `mp_en_i` = 1, an address frame is also accepted when every byte bit whose mask bit is 1 is itself 1 (the broadcast address). A byte that matches neither address is dropped.
- R9: The start bit is re-examined by a two-of-three vote on strobes 7, 8 and 9 after the falling edge. A 1 result abandons the frame with no flag change.
- R10: A stop bit voted as 0 sets `ferr_o`. In a frame that passes the filter, it does not prevent the byte from being loaded.
- R11: `done_clr_i` and `ferr_clr_i` clear their flags one cycle later. If a flag is set in the same cycle that its clear is high, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling strobe, 16 per bit time |
| long_frame_i | input | 1 | 0: short frame, 1: frame with ninth bit |
| mp_en_i | input | 1 | Multiprocessor address filter enable |
| addr_i | input | 8 | Own address byte |
| addr_mask_i | input | 8 | Address enable mask (1 = bit compared) |
| done_clr_i | input | 1 | Clears the frame-ready flag |
| ferr_clr_i | input | 1 | Clears the framing-error flag |
| data_o | output | 8 | Last accepted data byte |
| bit9_o | output | 1 | Last accepted ninth bit (or stop bit) |
| done_o | output | 1 | Frame-ready flag |
| ferr_o | output | 1 | Framing-error flag |

## Verification
The completion of a frame can coincide with a clear request on either flag. The bench sets up this case by raising both clear inputs before a frame that also carries a bad stop bit, and it keeps them raised until the first falling clock edge at which `done_o` reads 1. Both flags must read 1 at that moment, and the new byte must be present. The bench also checks the other collision: a frame that completes while the ready flag is still set must leave the outputs unchanged.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    SRX_IDLE,
    SRX_START,
    SRX_DATA,
    SRX_NINTH,
    SRX_STOP
  } srx_state_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/srx_vote.sv
module srx_vote #(
  parameter int OVS   = 16,
  parameter int CNT_W = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rx_i,
  output logic             bit_o,
  output logic             valid_o
);

  localparam int MID = OVS / 2;
  localparam logic [CNT_W-1:0] POS_A = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] POS_B = CNT_W'(MID);
  localparam logic [CNT_W-1:0] POS_C = CNT_W'(MID + 1);

  logic samp_a_q, samp_b_q;
  logic en_a, en_b;

  assign en_a = tick_i && (cnt_i == POS_A);
  assign en_b = tick_i && (cnt_i == POS_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    samp_a_q <= 1'b1;
    else if (en_a) samp_a_q <= rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    samp_b_q <= 1'b1;
    else if (en_b) samp_b_q <= rx_i;
  end

  // third sample is the live line value on the strobe after the middle
  assign valid_o = tick_i && (cnt_i == POS_C);
  assign bit_o   = (samp_a_q & samp_b_q) | (samp_a_q & rx_i) | (samp_b_q & rx_i);

endmodule

// File: rtl/srx_addr_match.sv
module srx_addr_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] mask_i,
  output logic         own_hit_o,
  output logic         bcast_hit_o
);

  logic [W-1:0] own_diff;
  logic [W-1:0] bcast_miss;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      own_diff[i]   = mask_i[i] & (byte_i[i] ^ addr_i[i]);
      bcast_miss[i] = mask_i[i] & ~byte_i[i];
    end
  end

  assign own_hit_o   = ~|own_diff;
  assign bcast_hit_o = ~|bcast_miss;

endmodule

// File: rtl/serial_rx_filter.sv
module serial_rx_filter #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              long_frame_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] addr_mask_i,
  input  logic              done_clr_i,
  input  logic              ferr_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              ferr_o
);

  import srx_pkg::*;

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic rx_s;
  srx_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic ninth_q, ninth_d;
  logic prev_q, prev_d;
  logic [DATA_W-1:0] data_q;
  logic bit9_q;
  logic done_q, done_d;
  logic ferr_q, ferr_d;
  logic vote_bit, vote_valid;
  logic own_hit, bcast_hit;
  logic last_bit, accept, load_en;

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  srx_vote #(.OVS(OVS), .CNT_W(CNT_W)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .cnt_i   (cnt_q),
    .rx_i    (rx_s),
    .bit_o   (vote_bit),
    .valid_o (vote_valid)
  );

  srx_addr_match #(.W(DATA_W)) u_match (
    .byte_i      (shreg_q),
    .addr_i      (addr_i),
    .mask_i      (addr_mask_i),
    .own_hit_o   (own_hit),
    .bcast_hit_o (bcast_hit)
  );

  // in short frames the stop bit stands in for the ninth bit
  assign last_bit = long_frame_i ? ninth_q : vote_bit;
  assign accept   = !done_q && (!mp_en_i || (last_bit && (own_hit || bcast_hit)));
  assign load_en  = vote_valid && (state_q == SRX_STOP) && accept;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    ninth_d = ninth_q;
    prev_d  = prev_q;
    done_d  = done_q;
    ferr_d  = ferr_q;

    if (done_clr_i) done_d = 1'b0;
    if (ferr_clr_i) ferr_d = 1'b0;

    if (tick_i) begin
      prev_d = rx_s;
      cnt_d  = ((state_q == SRX_IDLE) || (cnt_q == CNT_LAST)) ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        SRX_IDLE: begin
          if (prev_q && !rx_s) state_d = SRX_START;
        end
        SRX_START: begin
          if (vote_valid && vote_bit) begin
            state_d = SRX_IDLE;
            cnt_d   = '0;
          end else if (cnt_q == CNT_LAST) begin
            state_d = SRX_DATA;
            idx_d   = '0;
          end
        end
        SRX_DATA: begin
          if (vote_valid) shreg_d = {vote_bit, shreg_q[DATA_W-1:1]};
          if (cnt_q == CNT_LAST) begin
            if (idx_q == IDX_LAST) state_d = long_frame_i ? SRX_NINTH : SRX_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end
        end
        SRX_NINTH: begin
          if (vote_valid) ninth_d = vote_bit;
          if (cnt_q == CNT_LAST) state_d = SRX_STOP;
        end
        SRX_STOP: begin
          if (vote_valid) begin
            state_d = SRX_IDLE;
            cnt_d   = '0;
            if (!vote_bit) ferr_d = 1'b1;
            if (accept)    done_d = 1'b1;
          end
        end
        default: state_d = SRX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      ninth_q <= 1'b0;
      prev_q  <= 1'b0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      ninth_q <= ninth_d;
      prev_q  <= prev_d;
      done_q  <= done_d;
      ferr_q  <= ferr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit9_q <= 1'b0;
    end else if (load_en) begin
      data_q <= shreg_q;
      bit9_q <= last_bit;
    end
  end

  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign done_o = done_q;
  assign ferr_o = ferr_q;

endmodule

// File: rtl/serial_rx_filter_chk.sv
module serial_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              mp_en_i,
  input logic [DATA_W-1:0] addr_i,
  input logic [DATA_W-1:0] addr_mask_i,
  input logic              done_clr_i,
  input logic              ferr_clr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              bit9_o,
  input logic              done_o,
  input logic              ferr_o
);

  assert_hold_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> ($stable(data_o) && $stable(bit9_o)));

  assert_done_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(tick_i));

  assert_ferr_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_o) |-> $past(tick_i));

  assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_clr_i && !tick_i) |=> !done_o);

  assert_ferr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_o && ferr_clr_i && !tick_i) |=> !ferr_o);

  assert_mp_ninth_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) && $past(mp_en_i)) |-> bit9_o);

  // covers both the own-address rule (R7) and the broadcast rule (R8)
  assert_mp_addr_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) && $past(mp_en_i)) |->
      ((((data_o ^ $past(addr_i)) & $past(addr_mask_i)) == '0) ||
       ((data_o & $past(addr_mask_i)) == $past(addr_mask_i))));

endmodule

bind serial_rx_filter serial_rx_filter_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .mp_en_i     (mp_en_i),
  .addr_i      (addr_i),
  .addr_mask_i (addr_mask_i),
  .done_clr_i  (done_clr_i),
  .ferr_clr_i  (ferr_clr_i),
  .data_o      (data_o),
  .bit9_o      (bit9_o),
  .done_o      (done_o),
  .ferr_o      (ferr_o)
);

// File: tb/test_serial_rx_filter.sv
module test_serial_rx_filter;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = TICK_DIV * 16;

  logic       clk;
  logic       rst_n;
  logic       rx_i;
  logic       tick_i;
  logic       long_frame_i;
  logic       mp_en_i;
  logic [7:0] addr_i;
  logic [7:0] addr_mask_i;
  logic       done_clr_i;
  logic       ferr_clr_i;
  logic [7:0] data_o;
  logic       bit9_o;
  logic       done_o;
  logic       ferr_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  serial_rx_filter i_serial_rx_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx_i),
    .tick_i       (tick_i),
    .long_frame_i (long_frame_i),
    .mp_en_i      (mp_en_i),
    .addr_i       (addr_i),
    .addr_mask_i  (addr_mask_i),
    .done_clr_i   (done_clr_i),
    .ferr_clr_i   (ferr_clr_i),
    .data_o       (data_o),
    .bit9_o       (bit9_o),
    .done_o       (done_o),
    .ferr_o       (ferr_o)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    tick_i = 1'b0;
    for (int k = 0; ; k++) begin
      @(negedge clk);
      tick_i = ((k % TICK_DIV) == TICK_DIV - 1);
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    report();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_i = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic has9, input logic b9, input logic stopb);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    if (has9) hold_bit(b9);
    hold_bit(stopb);
    hold_bit(1'b1);
  endtask

  task automatic clear_flags();
    done_clr_i = 1'b1;
    ferr_clr_i = 1'b1;
    @(negedge clk);
    done_clr_i = 1'b0;
    ferr_clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rx_i = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 reset done", done_o, 0);
    check("R4 reset ferr", ferr_o, 0);
    check("R4 reset data", data_o, 0);
    check("R4 reset bit9", bit9_o, 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check("R4 low line no start done", done_o, 0);
    check("R4 low line no start ferr", ferr_o, 0);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic t_short_plain();
    long_frame_i = 1'b0;
    mp_en_i = 1'b0;
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R1 short data", data_o, 8'hA5);
    check("R1 short done", done_o, 1);
    check("R2 stop bit in bit9", bit9_o, 1);
    check("R10 no ferr on good stop", ferr_o, 0);
  endtask

  task automatic t_overrun();
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    check("R5 data kept while full", data_o, 8'hA5);
    check("R5 done kept", done_o, 1);
    done_clr_i = 1'b1;
    @(negedge clk);
    done_clr_i = 1'b0;
    @(negedge clk);
    check("R11 done cleared", done_o, 0);
    check("R5 data unchanged after clear", data_o, 8'hA5);
  endtask

  task automatic t_frame_err();
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    check("R10 ferr set", ferr_o, 1);
    check("R10 byte still loaded", data_o, 8'h5A);
    check("R10 done set", done_o, 1);
    check("R2 zero stop in bit9", bit9_o, 0);
    clear_flags();
    check("R11 ferr cleared", ferr_o, 0);
  endtask

  task automatic t_long();
    long_frame_i = 1'b1;
    send_frame(8'h81, 1'b1, 1'b0, 1'b1);
    check("R3 long data", data_o, 8'h81);
    check("R3 ninth 0", bit9_o, 0);
    clear_flags();
    send_frame(8'h7E, 1'b1, 1'b1, 1'b1);
    check("R3 long data 2", data_o, 8'h7E);
    check("R3 ninth 1", bit9_o, 1);
    clear_flags();
  endtask

  task automatic t_mp_filter();
    long_frame_i = 1'b1;
    mp_en_i = 1'b1;
    addr_i = 8'hC0;
    addr_mask_i = 8'hFD;
    send_frame(8'hC0, 1'b1, 1'b0, 1'b1);
    check("R6 data frame dropped", done_o, 0);
    check("R6 data unchanged", data_o, 8'h7E);
    send_frame(8'hC2, 1'b1, 1'b1, 1'b1);
    check("R7 own addr accepted", done_o, 1);
    check("R7 own addr data", data_o, 8'hC2);
    clear_flags();
    send_frame(8'hC4, 1'b1, 1'b1, 1'b1);
    check("R8 no-match dropped", done_o, 0);
    send_frame(8'hFF, 1'b1, 1'b1, 1'b1);
    check("R8 broadcast accepted", done_o, 1);
    check("R8 broadcast data", data_o, 8'hFF);
    clear_flags();
    long_frame_i = 1'b0;
    send_frame(8'hFD, 1'b0, 1'b0, 1'b1);
    check("R8 short broadcast data", data_o, 8'hFD);
    check("R2 short mp bit9", bit9_o, 1);
    clear_flags();
    send_frame(8'hC0, 1'b0, 1'b0, 1'b0);
    check("R6 short zero stop dropped", done_o, 0);
    check("R10 ferr in dropped frame", ferr_o, 1);
    clear_flags();
    mp_en_i = 1'b0;
  endtask

  task automatic t_false_start();
    long_frame_i = 1'b0;
    rx_i = 1'b0;
    repeat (12) @(negedge clk);
    rx_i = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R9 glitch no done", done_o, 0);
    check("R9 glitch no ferr", ferr_o, 0);
    send_frame(8'h33, 1'b0, 1'b0, 1'b1);
    check("R9 frame after glitch", data_o, 8'h33);
  endtask

  task automatic t_collide();
    bit seen;
    send_frame(8'h11, 1'b0, 1'b0, 1'b0);
    check("R10 ferr before collision", ferr_o, 1);
    done_clr_i = 1'b1;
    ferr_clr_i = 1'b1;
    seen = 0;
    fork
      send_frame(8'h96, 1'b0, 1'b0, 1'b0);
      begin
        @(negedge clk);
        for (int n = 0; n < 20 * BIT_CLKS && !seen; n++) begin
          @(negedge clk);
          if (done_o) begin
            seen = 1;
            done_clr_i = 1'b0;
            ferr_clr_i = 1'b0;
            check("R11 ferr set beats clear", ferr_o, 1);
            check("R11 new data under clear", data_o, 8'h96);
          end
        end
      end
    join
    done_clr_i = 1'b0;
    ferr_clr_i = 1'b0;
    check("R11 done set beats clear", seen, 1);
    check("R11 done held after release", done_o, 1);
    clear_flags();
  endtask

  initial begin
    rst_n = 1'b0;
    rx_i = 1'b0;
    long_frame_i = 1'b0;
    mp_en_i = 1'b0;
    addr_i = 8'h00;
    addr_mask_i = 8'h00;
    done_clr_i = 1'b0;
    ferr_clr_i = 1'b0;
    @(negedge clk);
    t_reset();
    t_short_plain();
    t_overrun();
    t_frame_err();
    t_long();
    t_mp_filter();
    t_false_start();
    clear_flags();
    t_collide();
    report();
  end

endmodule